// File: doc/BRIEF.md
# One-Time-Programmable Fuse Word Controller

This block sits between a simple register bus and a small array of one-time-programmable fuse words. Software first places a word address, and for programming also an unlock key, in a control register. It then starts one of two operations. A sense operation copies the stored word into a read-back register. A burn operation starts when a program-data register is written. It ORs that data into the stored word, so fuse bits can be set but never cleared.

Each operation holds a busy flag for a timed sequence: a relax interval, then a strobe interval, then a second relax interval. All lengths are counted in clock cycles and taken from a timing register. Any illegal request sets a sticky error flag, which only an explicit clear removes. The array itself is held in internal flip-flops, and every word is zero after reset.

The register bus is a single-cycle write strobe with an offset and write data. Reads are combinational on the offset. Word addresses are formed as bank × 8 + word, with the 3-bit word index in the low bits.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset, the control register (offset 0), the timing register (offset 2), the read-back register (offset 4) and every fuse word read zero.
- R2: The control register keeps the word address in bits 6:0 and the unlock field in bits 31:16. Both are written together and read back unchanged. Bit 8 reads busy and bit 9 reads error.
- R3: Writing the clear alias (offset 1) with bit 9 set clears the error flag. A write to the alias with bit 9 at zero leaves the flag set.
- R4: Writing 1 to bit 0 of the sense register (offset 3) senses the addressed word. By the cycle busy falls, the read-back register (offset 4) holds that word. Writing 0 to bit 0 starts nothing.
- R5: The timing register holds the burn strobe in bits 11:0, the relax field in bits 15:12 and the sense strobe in bits 21:16. Busy stays high for max(S+1, 2×(relax+1)) cycles, where S is the strobe field of the operation.
- R6: Writing the program-data register (offset 5) while the unlock field holds 0x3E77 starts a burn. The burn ORs the data into the addressed word.
- R7: A program-data write without the key sets error, starts no operation and leaves the array unchanged.
- R8: A sense or burn request while busy is high sets error and is otherwise ignored.
- R9: A sense or burn request to an address at or beyond the array size sets error and starts nothing.
- R10: The unlock field reads zero once a burn finishes, so a second burn needs the key reloaded.
- R11: Writes to the control and timing registers while busy is high are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wen | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 3 | Register offset for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register at reg_addr |

## Verification
A sequencer stuck in the wrong phase or counting from the wrong field shows up within one operation as a busy length that differs from max(S+1, 2×(relax+1)). A wrong latched address or a lost burn appears at the next sense as a read-back word that differs from the bench's OR-accumulated model. A missed or spurious error flag is visible in control bit 9 one cycle after the offending write. A stale unlock field shows in control bits 31:16 as soon as the burn's busy period ends.

// File: rtl/otp_pkg.sv
// Shared constants for the fuse controller: register offsets, control
// field positions, the unlock key and the sequencer phase type.
package otp_pkg;
    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] OFS_CTRL      = 3'd0;
    localparam logic [REG_AW-1:0] OFS_CTRL_CLR  = 3'd1;
    localparam logic [REG_AW-1:0] OFS_TIMING    = 3'd2;
    localparam logic [REG_AW-1:0] OFS_RD_CTRL   = 3'd3;
    localparam logic [REG_AW-1:0] OFS_RD_DATA   = 3'd4;
    localparam logic [REG_AW-1:0] OFS_PROG_DATA = 3'd5;

    localparam int CTRL_AW      = 7;
    localparam int BUSY_BIT     = 8;
    localparam int ERR_BIT      = 9;
    localparam int KEY_W        = 16;
    localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'h3E77;

    localparam int RELAX_W  = 4;
    localparam int RSTR_W   = 6;
    localparam int PSTR_W   = 12;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_RELAX_A,
        PH_STROBE,
        PH_RELAX_B
    } phase_t;
endpackage

// File: rtl/otp_seq.sv
// Operation sequencer: relax, strobe, relax.
// Assumes start is only raised while idle and that strobe/relax stay
// stable while busy. The total busy length is max(strobe+1, 2*(relax+1))
// cycles, because the strobe count includes both relax intervals.
// act pulses for one cycle on entry to the second relax interval.
module otp_seq
    import otp_pkg::*;
#(
    parameter int STR_W = PSTR_W,
    parameter int RLX_W = RELAX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [RLX_W-1:0] relax,
    input  logic [STR_W-1:0] strobe,
    output logic             busy,
    output logic             act
);
    localparam int CNT_W = STR_W + 1;

    phase_t           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] strobe_len;
    logic [CNT_W-1:0] relax_pair;
    logic [CNT_W-1:0] mid_len;
    logic [CNT_W-1:0] relax_ld;

    // Length of the middle interval once both relax intervals are removed.
    always_comb begin
        strobe_len = CNT_W'(strobe) + CNT_W'(1);
        relax_pair = (CNT_W'(relax) + CNT_W'(1)) << 1;
        mid_len    = (strobe_len > relax_pair) ? strobe_len - relax_pair : '0;
        relax_ld   = CNT_W'(relax);
    end

    // Phase and down-counter state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            act     <= 1'b0;
        end else begin
            act <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        phase_q <= PH_RELAX_A;
                        cnt_q   <= relax_ld;
                    end
                end
                PH_RELAX_A: begin
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end else if (mid_len == '0) begin
                        phase_q <= PH_RELAX_B;
                        cnt_q   <= relax_ld;
                        act     <= 1'b1;
                    end else begin
                        phase_q <= PH_STROBE;
                        cnt_q   <= mid_len - CNT_W'(1);
                    end
                end
                PH_STROBE: begin
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end else begin
                        phase_q <= PH_RELAX_B;
                        cnt_q   <= relax_ld;
                        act     <= 1'b1;
                    end
                end
                default: begin
                    if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
                    else             phase_q <= PH_IDLE;
                end
            endcase
        end
    end

    // Busy covers every phase except idle.
    assign busy = (phase_q != PH_IDLE);
endmodule

// File: rtl/otp_array.sv
// Fuse storage modelled as flip-flops, all zero after reset.
// On act, a burn ORs wdata into the word at idx, and a sense copies
// that word into rdata. Assumes idx is in range whenever act is high.
module otp_array #(
    parameter int WORDS  = 64,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act,
    input  logic              burn,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [WORDS];

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        // One fuse word: bits can only be set by a burn of this index.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem_q[i] <= '0;
            else if (act && burn && idx == IDX_W'(i))
                mem_q[i] <= mem_q[i] | wdata;
        end
    end

    // Sense capture into the read-back register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (act && !burn)
            rdata <= mem_q[idx];
    end
endmodule

// File: rtl/otp_fuse_ctrl.sv
// Register front end of the fuse controller. It decodes single-cycle
// register writes, checks the key, busy state and address range before
// starting a sense or burn, and keeps the sticky error flag. Reads are
// combinational on reg_addr. Assumes WORDS <= 128 so addresses fit in the
// 7-bit control field.
module otp_fuse_ctrl
    import otp_pkg::*;
#(
    parameter int WORDS  = 64,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);
    localparam int IDX_W = $clog2(WORDS);

    logic [KEY_W-1:0]   unlock_q;
    logic [CTRL_AW-1:0] waddr_q;
    logic               err_q;
    logic [RELAX_W-1:0] relax_q;
    logic [RSTR_W-1:0]  rstr_q;
    logic [PSTR_W-1:0]  pstr_q;
    logic               op_burn_q;
    logic [DATA_W-1:0]  pdata_q;

    logic wr_ctrl, wr_clr, wr_timing, sense_req, prog_req;
    logic addr_ok, sense_go, prog_go, err_set;
    logic busy, act;
    logic [PSTR_W-1:0]  strobe_sel;
    logic [DATA_W-1:0]  sense_data;

    // Write decode and admission checks for new operations.
    always_comb begin
        wr_ctrl   = reg_wen && reg_addr == OFS_CTRL;
        wr_clr    = reg_wen && reg_addr == OFS_CTRL_CLR;
        wr_timing = reg_wen && reg_addr == OFS_TIMING;
        sense_req = reg_wen && reg_addr == OFS_RD_CTRL && reg_wdata[0];
        prog_req  = reg_wen && reg_addr == OFS_PROG_DATA;
        addr_ok   = int'(waddr_q) < WORDS;
        sense_go  = sense_req && !busy && addr_ok;
        prog_go   = prog_req && !busy && addr_ok && unlock_q == UNLOCK_KEY;
        err_set   = (sense_req || prog_req) && !(sense_go || prog_go);
    end

    // Control register: address and unlock key, key spent by a burn.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlock_q <= '0;
            waddr_q  <= '0;
        end else if (act && op_burn_q) begin
            unlock_q <= '0;
        end else if (wr_ctrl && !busy) begin
            unlock_q <= reg_wdata[31:16];
            waddr_q  <= reg_wdata[CTRL_AW-1:0];
        end
    end

    // Sticky error flag, cleared only through the clear alias.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (err_set)
            err_q <= 1'b1;
        else if (wr_clr && reg_wdata[ERR_BIT])
            err_q <= 1'b0;
    end

    // Timing register, frozen while an operation runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            relax_q <= '0;
            rstr_q  <= '0;
            pstr_q  <= '0;
        end else if (wr_timing && !busy) begin
            pstr_q  <= reg_wdata[11:0];
            relax_q <= reg_wdata[15:12];
            rstr_q  <= reg_wdata[21:16];
        end
    end

    // Operation kind and burn data latched at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_burn_q <= 1'b0;
            pdata_q   <= '0;
        end else if (prog_go) begin
            op_burn_q <= 1'b1;
            pdata_q   <= reg_wdata;
        end else if (sense_go) begin
            op_burn_q <= 1'b0;
        end
    end

    // Strobe length of the running operation.
    assign strobe_sel = op_burn_q ? pstr_q : PSTR_W'(rstr_q);

    otp_seq #(
        .STR_W (PSTR_W),
        .RLX_W (RELAX_W)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (sense_go || prog_go),
        .relax  (relax_q),
        .strobe (strobe_sel),
        .busy   (busy),
        .act    (act)
    );

    otp_array #(
        .WORDS  (WORDS),
        .DATA_W (DATA_W)
    ) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .act   (act),
        .burn  (op_burn_q),
        .idx   (waddr_q[IDX_W-1:0]),
        .wdata (pdata_q),
        .rdata (sense_data)
    );

    // Register read multiplexer.
    always_comb begin
        case (reg_addr)
            OFS_CTRL:    reg_rdata = {unlock_q, 6'b0, err_q, busy, 1'b0, waddr_q};
            OFS_TIMING:  reg_rdata = {10'b0, rstr_q, relax_q, pstr_q};
            OFS_RD_DATA: reg_rdata = sense_data;
            default:     reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/otp_fuse_ctrl_chk.sv
// Protocol checker for otp_fuse_ctrl, attached by bind. It observes the
// bus inputs and the controller's key, address, error and busy state.
module otp_fuse_ctrl_chk
    import otp_pkg::*;
#(
    parameter int WORDS = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wen,
    input logic [REG_AW-1:0]  reg_addr,
    input logic               wd0,
    input logic               busy,
    input logic               err_q,
    input logic [KEY_W-1:0]   unlock_q,
    input logic [CTRL_AW-1:0] waddr_q,
    input logic               op_burn_q
);
    logic start_req;
    assign start_req = reg_wen &&
                       ((reg_addr == OFS_RD_CTRL && wd0) || reg_addr == OFS_PROG_DATA);

    AST_BUSY_START_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_req) |=> err_q); // R8

    AST_NOKEY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && reg_wen && reg_addr == OFS_PROG_DATA && unlock_q != UNLOCK_KEY)
        |=> (err_q && !busy)); // R7

    AST_RANGE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_req && int'(waddr_q) >= WORDS) |=> (err_q && !busy)); // R9

    AST_KEY_SPENT: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && op_burn_q) |-> (unlock_q == '0)); // R10

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(waddr_q)); // R11
endmodule

bind otp_fuse_ctrl otp_fuse_ctrl_chk #(.WORDS(WORDS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wen   (reg_wen),
    .reg_addr  (reg_addr),
    .wd0       (reg_wdata[0]),
    .busy      (busy),
    .err_q     (err_q),
    .unlock_q  (unlock_q),
    .waddr_q   (waddr_q),
    .op_burn_q (op_burn_q)
);

// File: tb/sim_otp_fuse_ctrl.sv
// Self-checking bench: directed corner cases plus seeded random sense and
// burn operations, compared against a bench-side OR-accumulating model.
module sim_otp_fuse_ctrl;
    import otp_pkg::*;

    localparam int WORDS = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic [2:0]  reg_addr = OFS_CTRL;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [WORDS];

    always #4 clk = ~clk;

    otp_fuse_ctrl #(.WORDS(WORDS), .DATA_W(32)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wen   (reg_wen),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    function automatic int exp_busy(input int strobe, input int relax);
        int a = strobe + 1;
        int b = 2 * (relax + 1);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [31:0] timing_word(input int r, input int rs, input int ps);
        return {10'b0, 6'(rs), 4'(r), 12'(ps)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0; reg_addr = OFS_CTRL;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
        reg_addr = OFS_CTRL;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        reg_addr = OFS_CTRL;
        #1;
        while (reg_rdata[BUSY_BIT] && n < 20000) begin
            n++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic sense(input int a, output logic [31:0] d, output int n);
        wr(OFS_CTRL, 32'(a));
        wr(OFS_RD_CTRL, 32'h1);
        wait_idle(n);
        rd(OFS_RD_DATA, d);
    endtask

    task automatic burn(input int a, input logic [31:0] d, output int n);
        wr(OFS_CTRL, {UNLOCK_KEY, 9'b0, 7'(a)});
        wr(OFS_PROG_DATA, d);
        wait_idle(n);
    endtask

    task automatic clear_err();
        wr(OFS_CTRL_CLR, 32'h200);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int n;
        void'($urandom(32'd2024));
        for (int i = 0; i < WORDS; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(OFS_CTRL, d);    check("R1 ctrl", d, 32'h0);
        rd(OFS_TIMING, d);  check("R1 timing", d, 32'h0);
        rd(OFS_RD_DATA, d); check("R1 rdata", d, 32'h0);
        sense(37, d, n);    check("R1 word zero", d, 32'h0);
        check("R5 default busy", 32'(n), 32'(exp_busy(0, 0)));

        // R2 control field readback
        wr(OFS_CTRL, 32'hABCD_FF2A);
        rd(OFS_CTRL, d);    check("R2 ctrl readback", d, 32'hABCD_002A);

        // R5 timing readback and fields
        wr(OFS_TIMING, timing_word(2, 9, 30));
        rd(OFS_TIMING, d);  check("R5 timing readback", d, timing_word(2, 9, 30));

        // R4 writing 0 to the sense bit starts nothing
        wr(OFS_CTRL, 32'd5);
        wr(OFS_RD_CTRL, 32'h0);
        rd(OFS_CTRL, d);    check("R4 no start busy", 32'(d[BUSY_BIT]), 32'h0);

        // R6 burn ORs bits, R10 key spent afterwards
        burn(5, 32'h0000_000F, n);
        check("R5 burn busy", 32'(n), 32'(exp_busy(30, 2)));
        model[5] |= 32'h0000_000F;
        rd(OFS_CTRL, d);    check("R10 key cleared", 32'(d[31:16]), 32'h0);
        burn(5, 32'h0000_00F0, n);
        model[5] |= 32'h0000_00F0;
        sense(5, d, n);     check("R6 OR accumulate", d, 32'h0000_00FF);
        check("R5 sense busy", 32'(n), 32'(exp_busy(9, 2)));

        // R10 second burn without reloading key errors
        wr(OFS_CTRL, {UNLOCK_KEY, 9'b0, 7'd6});
        wr(OFS_PROG_DATA, 32'h1);
        wait_idle(n);
        wr(OFS_PROG_DATA, 32'h2);
        rd(OFS_CTRL, d);    check("R10 reuse key err", 32'(d[ERR_BIT]), 32'h1);
        model[6] |= 32'h1;
        clear_err();

        // R7 no key: error, array unchanged
        wr(OFS_CTRL, 32'h1234_0007);
        wr(OFS_PROG_DATA, 32'hFFFF_FFFF);
        rd(OFS_CTRL, d);    check("R7 err set", 32'(d[ERR_BIT]), 32'h1);
        check("R7 not busy", 32'(d[BUSY_BIT]), 32'h0);
        // R3 writing 0 to bit 9 of clear alias keeps error
        wr(OFS_CTRL_CLR, 32'h0000_0100);
        rd(OFS_CTRL, d);    check("R3 keep err", 32'(d[ERR_BIT]), 32'h1);
        clear_err();
        rd(OFS_CTRL, d);    check("R3 err cleared", 32'(d[ERR_BIT]), 32'h0);
        sense(7, d, n);     check("R7 word unchanged", d, 32'h0);

        // R9 out-of-range address
        wr(OFS_CTRL, 32'd100);
        wr(OFS_RD_CTRL, 32'h1);
        rd(OFS_CTRL, d);    check("R9 sense err", 32'(d[ERR_BIT]), 32'h1);
        check("R9 sense no busy", 32'(d[BUSY_BIT]), 32'h0);
        clear_err();
        wr(OFS_CTRL, {UNLOCK_KEY, 9'b0, 7'd64});
        wr(OFS_PROG_DATA, 32'hFFFF_FFFF);
        rd(OFS_CTRL, d);    check("R9 burn err", 32'(d[ERR_BIT]), 32'h1);
        check("R9 burn no busy", 32'(d[BUSY_BIT]), 32'h0);
        clear_err();

        // R8 start while busy, R11 ctrl/timing writes ignored while busy
        wr(OFS_TIMING, timing_word(3, 50, 100));
        wr(OFS_CTRL, 32'd5);
        wr(OFS_RD_CTRL, 32'h1);
        wr(OFS_RD_CTRL, 32'h1);
        rd(OFS_CTRL, d);    check("R8 busy start err", 32'(d[ERR_BIT]), 32'h1);
        wr(OFS_CTRL, {UNLOCK_KEY, 9'b0, 7'd9});
        wr(OFS_TIMING, timing_word(0, 0, 0));
        wr(OFS_PROG_DATA, 32'hFFFF_0000);
        wait_idle(n);
        rd(OFS_CTRL, d);    check("R11 ctrl ignored", d, 32'h0000_0205);
        rd(OFS_TIMING, d);  check("R11 timing ignored", d, timing_word(3, 50, 100));
        rd(OFS_RD_DATA, d); check("R4 sense data", d, model[5]);
        clear_err();
        sense(9, d, n);     check("R8 burn ignored", d, model[9]);

        // Random mix of sense and burn with random timing
        for (int it = 0; it < 60; it++) begin
            int a = int'($urandom_range(WORDS - 1, 0));
            int r = int'($urandom_range(3, 0));
            int rs = int'($urandom_range(30, 0));
            int ps = int'($urandom_range(60, 0));
            logic [31:0] v = $urandom();
            wr(OFS_TIMING, timing_word(r, rs, ps));
            if ($urandom_range(1, 0) == 1) begin
                burn(a, v, n);
                model[a] |= v;
                check("R5 rand burn busy", 32'(n), 32'(exp_busy(ps, r)));
            end else begin
                sense(a, d, n);
                check("R4 rand sense", d, model[a]);
                check("R5 rand sense busy", 32'(n), 32'(exp_busy(rs, r)));
            end
            rd(OFS_CTRL, d);
            check("R2 rand ctrl", d, {16'h0, 9'b0, 7'(a)});
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule